// File: doc/BRIEF.md
# Prioritized Core Event Controller

This block decides which event the processor core should service next. Sixteen event levels are ranked by number, with level 0 the most urgent. The seven lowest-numbered levels are fixed core events: emulation, reset, non-maskable interrupt, exception, a reserved slot, hardware error and core timer. The nine levels from 7 to 15 are general purpose. A front-end mapper takes a bank of level-sensitive peripheral request lines. It gates each line with its own enable bit and steers it onto a programmable general-purpose level.

Raised events are latched as pending and filtered by a mask. The controller dispatches the most urgent eligible one only when it outranks every level already in service. On dispatch it issues a one-cycle strobe with the level number and that level's 32-bit handler address, and marks the level as in service. A return strobe from the core ends service of the current, most urgent in-service level, so nested handlers unwind in order. A simple register port writes the handler addresses, the mask, the source enables and the mapping. The same port reads them back, together with the pending and in-service sets.

Top module: `evt_prio_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the pending and in-service sets and the dispatch strobe. It zeroes all handler addresses and source enables, and masks levels 5 to 15. It sets each source's level to the default: sources 0 to 3 to level 7, source 4 to level 8, and sources 5 and up to level 11.
- R2: When several eligible levels are pending, the lowest-numbered one is dispatched. The strobe `disp_valid` is high for one cycle, one clock after the clock that latched the pending bit, and `disp_level` carries the level number.
- R3: Mask register address 0x10 bit n = 1 enables level n for n from 5 to 15. Bits 0 to 4 always read as 1 and writes to them are ignored, so levels 0 to 4 cannot be masked. A masked level stays pending but is not dispatched. Core event input bit 4 (the reserved level) is ignored and never becomes pending.
- R4: A pending level is dispatched only if its number is lower than the lowest-numbered level in service. `in_service` bit n is 1 while level n is in service.
- R5: A return strobe clears the lowest-numbered in-service bit at the next clock. With nothing in service it has no effect.
- R6: A pending bit stays set until its level is dispatched, even after the request is removed. A request still held at dispatch sets the bit again.
- R7: Source enable register address 0x11 bit s = 1 passes peripheral request s. A disabled request leaves the pending set unchanged.
- R8: Map register at address 0x20+s holds the level number (7 to 15) of source s in bits [3:0]. A write of a value below 7 is ignored.
- R9: Handler address registers sit at addresses 0x00 to 0x0F, one per level. `disp_vector` equals the register of the dispatched level as it stood at the dispatch clock.
- R10: Address 0x12 reads the pending set and 0x13 reads the in-service set, both in bits [15:0]. Any unmapped address reads 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_req | input | NUM_SRC | Level-sensitive peripheral requests |
| core_evt | input | 7 | Core event raise pulses for levels 0..6 (bit 4 ignored) |
| evt_ret | input | 1 | Return-from-event strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | VEC_W | Register write data |
| reg_rdata | output | VEC_W | Register read data (combinational) |
| disp_valid | output | 1 | One-cycle dispatch strobe |
| disp_level | output | 4 | Dispatched level number |
| disp_vector | output | VEC_W | Handler address of the dispatched level |
| in_service | output | 16 | Set of levels in service |

## Verification
A corrupted pending bit shows up as a dispatch that is missing, extra or late. This is visible at the strobe one clock after the clock that should have latched it, and in the pending read-back in the cycle in between. A corrupted in-service set appears at once on `in_service`. It also changes which later events are held off, so it surfaces at the next dispatch or return. A reference model of pending, in-service, mask, enables, mapping and handler addresses is compared every cycle against the strobe, level, address, in-service set and the read data of a randomly chosen register.

// File: rtl/evc_pkg.sv
`timescale 1ns/1ps
package evc_pkg;
    localparam int NUM_LVL  = 16;
    localparam int LVL_W    = 4;
    localparam int NUM_CORE = 7;
    localparam int GP_FIRST = 7;
    localparam int RSVD_LVL = 4;
    localparam int ADDR_W   = 6;

    typedef logic [NUM_LVL-1:0] lvl_vec_t;

    localparam lvl_vec_t NOMASK = lvl_vec_t'(16'h001F);

    localparam logic [ADDR_W-1:0] A_MASK = 6'h10;
    localparam logic [ADDR_W-1:0] A_EN   = 6'h11;
    localparam logic [ADDR_W-1:0] A_PEND = 6'h12;
    localparam logic [ADDR_W-1:0] A_INSV = 6'h13;
    localparam logic [ADDR_W-1:0] A_MAP  = 6'h20;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
    } pick_t;

    typedef enum logic [2:0] {
        SEL_VEC, SEL_MASK, SEL_EN, SEL_PEND, SEL_INSV, SEL_MAP, SEL_NONE
    } reg_sel_t;

    // most urgent (lowest-numbered) set bit
    function automatic pick_t first_set(lvl_vec_t v);
        pick_t p;
        p = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.level = LVL_W'(i);
            end
        end
        return p;
    endfunction

    function automatic lvl_vec_t onehot(logic [LVL_W-1:0] l);
        return lvl_vec_t'(1) << l;
    endfunction

    function automatic lvl_vec_t at_or_above(logic [LVL_W-1:0] l);
        lvl_vec_t r;
        for (int i = 0; i < NUM_LVL; i++) r[i] = (i <= int'(l));
        return r;
    endfunction

    function automatic logic [LVL_W-1:0] dflt_map(int s);
        if (s < 4)       return LVL_W'(GP_FIRST);
        else if (s == 4) return LVL_W'(GP_FIRST + 1);
        else             return LVL_W'(GP_FIRST + 4);
    endfunction

    function automatic logic map_ok(logic [LVL_W-1:0] l);
        return int'(l) >= GP_FIRST;
    endfunction

    function automatic reg_sel_t decode_addr(logic [ADDR_W-1:0] a, int nsrc);
        if (int'(a) < NUM_LVL)                        return SEL_VEC;
        else if (a == A_MASK)                         return SEL_MASK;
        else if (a == A_EN)                           return SEL_EN;
        else if (a == A_PEND)                         return SEL_PEND;
        else if (a == A_INSV)                         return SEL_INSV;
        else if (a >= A_MAP && int'(a - A_MAP) < nsrc) return SEL_MAP;
        else                                          return SEL_NONE;
    endfunction
endpackage

// File: rtl/evc_mapper.sv
`timescale 1ns/1ps
module evc_mapper
    import evc_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC-1:0]       src_en,
    input  logic [NUM_SRC*LVL_W-1:0] map_flat,
    output lvl_vec_t                 gp_raise
);
    lvl_vec_t hit [NUM_SRC];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign hit[s] = (req[s] && src_en[s]) ? onehot(map_flat[s*LVL_W +: LVL_W]) : '0;
    end

    always_comb begin
        gp_raise = '0;
        for (int s = 0; s < NUM_SRC; s++) gp_raise = gp_raise | hit[s];
    end
endmodule

// File: rtl/evc_regs.sv
`timescale 1ns/1ps
module evc_regs
    import evc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [VEC_W-1:0]         wdata,
    output logic [VEC_W-1:0]         rdata,
    input  lvl_vec_t                 pend,
    input  lvl_vec_t                 insv,
    input  logic [LVL_W-1:0]         sel_lvl,
    output logic [VEC_W-1:0]         sel_vec,
    output lvl_vec_t                 eff_mask,
    output logic [NUM_SRC-1:0]       src_en,
    output logic [NUM_SRC*LVL_W-1:0] map_flat
);
    localparam int SRC_W = $clog2(NUM_SRC);

    logic [VEC_W-1:0]   vec_q [NUM_LVL];
    lvl_vec_t           mask_q;
    logic [NUM_SRC-1:0] en_q;
    logic [LVL_W-1:0]   map_q [NUM_SRC];
    reg_sel_t           sel;

    assign sel = decode_addr(addr, NUM_SRC);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LVL; i++) vec_q[i] <= '0;
            for (int s = 0; s < NUM_SRC; s++) map_q[s] <= dflt_map(s);
            mask_q <= '0;
            en_q   <= '0;
        end else if (wr) begin
            case (sel)
                SEL_VEC:  vec_q[addr[LVL_W-1:0]] <= wdata;
                SEL_MASK: mask_q <= wdata[NUM_LVL-1:0] & ~NOMASK;
                SEL_EN:   en_q   <= wdata[NUM_SRC-1:0];
                SEL_MAP:  if (map_ok(wdata[LVL_W-1:0])) map_q[addr[SRC_W-1:0]] <= wdata[LVL_W-1:0];
                default:  ;
            endcase
        end
    end

    assign eff_mask = mask_q | NOMASK;
    assign src_en   = en_q;
    assign sel_vec  = vec_q[sel_lvl];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
        assign map_flat[s*LVL_W +: LVL_W] = map_q[s];
        // R8
        map_range_chk: assert property (@(posedge clk) disable iff (rst)
            int'(map_q[s]) >= GP_FIRST);
    end

    always_comb begin
        case (sel)
            SEL_VEC:  rdata = vec_q[addr[LVL_W-1:0]];
            SEL_MASK: rdata = VEC_W'(eff_mask);
            SEL_EN:   rdata = VEC_W'(en_q);
            SEL_PEND: rdata = VEC_W'(pend);
            SEL_INSV: rdata = VEC_W'(insv);
            SEL_MAP:  rdata = VEC_W'(map_q[addr[SRC_W-1:0]]);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/evc_core.sv
`timescale 1ns/1ps
module evc_core
    import evc_pkg::*;
#(
    parameter int VEC_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CORE-1:0] core_evt,
    input  lvl_vec_t            gp_raise,
    input  lvl_vec_t            eff_mask,
    input  logic                evt_ret,
    input  logic [VEC_W-1:0]    sel_vec,
    output logic [LVL_W-1:0]    sel_lvl,
    output lvl_vec_t            pend_q,
    output lvl_vec_t            insv_q,
    output logic                disp_valid,
    output logic [LVL_W-1:0]    disp_level,
    output logic [VEC_W-1:0]    disp_vector
);
    lvl_vec_t core_raise, raise, go_bit, ret_bit;
    pick_t    cand, cur;
    logic     go;

    always_comb begin
        core_raise = '0;
        for (int i = 0; i < NUM_CORE; i++)
            if (i != RSVD_LVL) core_raise[i] = core_evt[i];
    end

    assign raise = core_raise | gp_raise;

    always_comb begin
        cand = first_set(pend_q & eff_mask);
        cur  = first_set(insv_q);
        go   = cand.valid && (!cur.valid || cand.level < cur.level);
    end

    assign sel_lvl = cand.level;
    assign go_bit  = go ? onehot(cand.level) : '0;
    assign ret_bit = (evt_ret && cur.valid) ? onehot(cur.level) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= '0;
            insv_q      <= '0;
            disp_valid  <= 1'b0;
            disp_level  <= '0;
            disp_vector <= '0;
        end else begin
            pend_q     <= (pend_q & ~go_bit) | raise;
            insv_q     <= (insv_q & ~ret_bit) | go_bit;
            disp_valid <= go;
            if (go) begin
                disp_level  <= cand.level;
                disp_vector <= sel_vec;
            end
        end
    end

    // R4
    nest_order_chk: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (($past(insv_q) & at_or_above(disp_level)) == '0));

    // R2
    disp_marks_chk: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> insv_q[disp_level]);

    // R3
    rsvd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_q[RSVD_LVL] && !insv_q[RSVD_LVL]);

    // R3
    mask_obey_chk: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (($past(eff_mask) & onehot(disp_level)) != '0));

    // R5
    ret_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_ret && cur.valid) |=> !insv_q[$past(cur.level)]);
endmodule

// File: rtl/evt_prio_ctrl.sv
`timescale 1ns/1ps
module evt_prio_ctrl
    import evc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  periph_req,
    input  logic [NUM_CORE-1:0] core_evt,
    input  logic                evt_ret,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [VEC_W-1:0]    reg_wdata,
    output logic [VEC_W-1:0]    reg_rdata,
    output logic                disp_valid,
    output logic [LVL_W-1:0]    disp_level,
    output logic [VEC_W-1:0]    disp_vector,
    output logic [NUM_LVL-1:0]  in_service
);
    lvl_vec_t                 gp_raise, eff_mask, pend_q, insv_q;
    logic [NUM_SRC-1:0]       src_en;
    logic [NUM_SRC*LVL_W-1:0] map_flat;
    logic [LVL_W-1:0]         sel_lvl;
    logic [VEC_W-1:0]         sel_vec;

    evc_mapper #(.NUM_SRC(NUM_SRC)) u_mapper (
        .req(periph_req), .src_en(src_en), .map_flat(map_flat), .gp_raise(gp_raise)
    );

    evc_regs #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .pend(pend_q), .insv(insv_q), .sel_lvl(sel_lvl),
        .sel_vec(sel_vec), .eff_mask(eff_mask), .src_en(src_en), .map_flat(map_flat)
    );

    evc_core #(.VEC_W(VEC_W)) u_core (
        .clk(clk), .rst(rst), .core_evt(core_evt), .gp_raise(gp_raise),
        .eff_mask(eff_mask), .evt_ret(evt_ret), .sel_vec(sel_vec), .sel_lvl(sel_lvl),
        .pend_q(pend_q), .insv_q(insv_q), .disp_valid(disp_valid),
        .disp_level(disp_level), .disp_vector(disp_vector)
    );

    assign in_service = insv_q;
endmodule

// File: tb/evt_prio_ctrl_bench.sv
`timescale 1ns/1ps
module evt_prio_ctrl_bench;
    localparam int NS = 8;
    localparam logic [5:0] AMSK = 6'h10, AEN = 6'h11, APND = 6'h12, AISV = 6'h13, AMAP = 6'h20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NS-1:0] periph_req = '0;
    logic [6:0]  core_evt = '0;
    logic        evt_ret = 1'b0, reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, disp_vector;
    logic        disp_valid;
    logic [3:0]  disp_level;
    logic [15:0] in_service;

    always #2 clk = ~clk;

    evt_prio_ctrl #(.NUM_SRC(NS), .VEC_W(32)) u_evt_prio_ctrl (
        .clk(clk), .rst(rst), .periph_req(periph_req), .core_evt(core_evt),
        .evt_ret(evt_ret), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .disp_valid(disp_valid), .disp_level(disp_level),
        .disp_vector(disp_vector), .in_service(in_service)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] rd_seen;

    // reference state
    logic [15:0] m_pend, m_isr, m_mask;
    logic [NS-1:0] m_en;
    logic [3:0]  m_map [NS];
    logic [31:0] m_vec [16];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] lowest(input logic [15:0] v);
        logic [4:0] r = 5'd16;
        for (int i = 15; i >= 0; i--) if (v[i]) r = i[4:0];
        return r;
    endfunction

    function automatic logic [3:0] base_map(input int s);
        return (s < 4) ? 4'd7 : (s == 4) ? 4'd8 : 4'd11;
    endfunction

    function automatic logic [31:0] m_read(input logic [5:0] a);
        if (a < 6'd16) return m_vec[a[3:0]];
        if (a == AMSK) return {16'h0, m_mask | 16'h001F};
        if (a == AEN)  return {24'h0, m_en};
        if (a == APND) return {16'h0, m_pend};
        if (a == AISV) return {16'h0, m_isr};
        if (a >= AMAP && a < AMAP + 6'(NS)) return {28'h0, m_map[a - AMAP]};
        return 32'h0;
    endfunction

    task automatic step(input logic [NS-1:0] rq, input logic [6:0] ce, input logic rt,
                        input logic wr, input logic [5:0] ad, input logic [31:0] wd);
        logic [15:0] raise;
        logic [4:0]  cand, cur;
        logic        go;
        logic [31:0] exp_vec;
        @(negedge clk);
        periph_req = rq; core_evt = ce; evt_ret = rt;
        reg_wr = wr; reg_addr = ad; reg_wdata = wd;
        #1;
        rd_seen = reg_rdata;
        if (!rst) chk("R10 R3 R8 R9 register read", rd_seen, m_read(ad));
        raise = '0;
        for (int l = 0; l < 7; l++) if (l != 4 && ce[l]) raise[l] = 1'b1;
        for (int s = 0; s < NS; s++) if (rq[s] && m_en[s]) raise[m_map[s]] = 1'b1;
        cand = lowest(m_pend & (m_mask | 16'h001F));
        cur  = lowest(m_isr);
        go   = (cand != 5'd16) && (cand < cur);
        exp_vec = go ? m_vec[cand[3:0]] : 32'h0;
        @(posedge clk);
        #1;
        if (rst) begin
            go = 1'b0;
            m_pend = '0; m_isr = '0; m_mask = '0; m_en = '0;
            for (int s = 0; s < NS; s++) m_map[s] = base_map(s);
            for (int l = 0; l < 16; l++) m_vec[l] = '0;
        end else begin
            if (rt && cur != 5'd16) m_isr[cur[3:0]] = 1'b0;
            if (go) begin
                m_isr[cand[3:0]]  = 1'b1;
                m_pend[cand[3:0]] = 1'b0;
            end
            m_pend = m_pend | raise;
            if (wr) begin
                if (ad < 6'd16) m_vec[ad[3:0]] = wd;
                else if (ad == AMSK) m_mask = wd[15:0] & 16'hFFE0;
                else if (ad == AEN) m_en = wd[NS-1:0];
                else if (ad >= AMAP && ad < AMAP + 6'(NS) && wd[3:0] >= 4'd7) m_map[ad - AMAP] = wd[3:0];
            end
        end
        chk("R2 R4 dispatch strobe", {31'h0, disp_valid}, {31'h0, go});
        if (go) begin
            chk("R2 dispatch level", {28'h0, disp_level}, {27'h0, cand});
            chk("R9 dispatch vector", disp_vector, exp_vec);
        end
        chk("R4 R5 in_service", {16'h0, in_service}, {16'h0, m_isr});
    endtask

    task automatic idle();
        step('0, '0, 1'b0, 1'b0, APND, '0);
    endtask
    task automatic wreg(input logic [5:0] a, input logic [31:0] d);
        step('0, '0, 1'b0, 1'b1, a, d);
    endtask
    task automatic rreg(input logic [5:0] a);
        step('0, '0, 1'b0, 1'b0, a, '0);
    endtask
    task automatic ret1();
        step('0, '0, 1'b1, 1'b0, APND, '0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no finish expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) idle();
        rst = 1'b0;
        // R1 reset state
        chk("R1 no dispatch after reset", {31'h0, disp_valid}, 32'h0);
        chk("R1 in_service clear", {16'h0, in_service}, 32'h0);
        rreg(AMSK);     chk("R1 mask reset", rd_seen, 32'h1F);
        rreg(AMAP + 5); chk("R1 default map timer", rd_seen, 32'd11);
        rreg(AMAP + 0); chk("R1 default map error", rd_seen, 32'd7);
        rreg(AEN);      chk("R1 enables off", rd_seen, 32'h0);

        for (int l = 0; l < 16; l++) wreg(6'(l), 32'h8000_0000 + 32'(l) * 32'h10);
        wreg(AMSK, 32'hFFFF);
        wreg(AEN, 32'hFF);

        // R2 R9 non-maskable event
        step('0, 7'b0000100, 1'b0, 1'b0, APND, '0);
        idle();
        chk("R2 nmi dispatched", {31'h0, disp_valid}, 32'h1);
        chk("R2 nmi level", {28'h0, disp_level}, 32'd2);
        chk("R9 nmi vector", disp_vector, 32'h8000_0020);

        // R4 exception held off by level 2
        step('0, 7'b0001000, 1'b0, 1'b0, APND, '0);
        idle();
        chk("R4 exception held off", {31'h0, disp_valid}, 32'h0);
        rreg(APND);
        chk("R6 exception pending", rd_seen, 32'h0008);
        chk("R4 nesting in_service", {16'h0, in_service}, 32'h0004);

        // R5 return unwinds
        ret1();
        chk("R5 return clears level 2", {16'h0, in_service}, 32'h0);
        idle();
        chk("R5 deferred exception dispatched", {28'h0, disp_level}, 32'd3);
        ret1();
        ret1();
        chk("R5 return with nothing in service", {16'h0, in_service}, 32'h0);

        // R3 reserved level
        step('0, 7'b0010000, 1'b0, 1'b0, APND, '0);
        idle();
        chk("R3 reserved not dispatched", {31'h0, disp_valid}, 32'h0);
        rreg(APND);
        chk("R3 reserved never pending", rd_seen, 32'h0);

        // R3 R6 masked level stays pending
        wreg(AMSK, 32'hF7FF);
        step(8'h20, '0, 1'b0, 1'b0, APND, '0);
        idle(); idle();
        chk("R3 masked level not dispatched", {31'h0, disp_valid}, 32'h0);
        rreg(APND);
        chk("R6 pending kept after request drop", rd_seen, 32'h0800);
        wreg(AMSK, 32'hFFFF);
        idle();
        chk("R3 unmasked level dispatched", {27'h0, disp_valid, disp_level}, 32'h1B);
        ret1();

        // R3 low levels unmaskable
        wreg(AMSK, 32'h0);
        rreg(AMSK);
        chk("R3 low mask bits stuck", rd_seen, 32'h1F);
        step('0, 7'b0000100, 1'b0, 1'b0, APND, '0);
        idle();
        chk("R3 nmi ignores mask", {27'h0, disp_valid, disp_level}, 32'h12);
        ret1();
        wreg(AMSK, 32'hFFFF);

        // R7 disabled source
        wreg(AEN, 32'hFE);
        step(8'h01, '0, 1'b0, 1'b0, APND, '0);
        idle();
        chk("R7 disabled source no dispatch", {31'h0, disp_valid}, 32'h0);
        rreg(APND);
        chk("R7 disabled source not pending", rd_seen, 32'h0);
        wreg(AEN, 32'hFF);

        // R8 mapping
        wreg(AMAP, 32'd3);
        rreg(AMAP);
        chk("R8 illegal map ignored", rd_seen, 32'd7);
        wreg(AMAP, 32'd14);
        rreg(AMAP);
        chk("R8 map written", rd_seen, 32'd14);
        step(8'h01, '0, 1'b0, 1'b0, APND, '0);
        idle();
        chk("R8 remapped source level", {27'h0, disp_valid, disp_level}, 32'h1E);
        ret1();

        // R2 simultaneous arrivals
        step(8'h10, 7'b1000000, 1'b0, 1'b0, APND, '0);
        idle();
        chk("R2 timer beats level 8", {27'h0, disp_valid, disp_level}, 32'h16);
        idle();
        chk("R4 level 8 waits", {31'h0, disp_valid}, 32'h0);
        ret1();
        idle();
        chk("R2 level 8 after return", {27'h0, disp_valid, disp_level}, 32'h18);
        ret1();

        // R6 held level request re-dispatches
        step(8'h10, '0, 1'b0, 1'b0, APND, '0);
        step(8'h10, '0, 1'b0, 1'b0, APND, '0);
        step(8'h10, '0, 1'b1, 1'b0, APND, '0);
        step(8'h10, '0, 1'b0, 1'b0, APND, '0);
        chk("R6 held request dispatched again", {27'h0, disp_valid, disp_level}, 32'h18);
        for (int i = 0; i < 4; i++) ret1();

        // R10 unmapped
        rreg(6'h3F);
        chk("R10 unmapped reads zero", rd_seen, 32'h0);
        rreg(AISV);

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [NS-1:0] rq;
            logic [6:0]    ce;
            logic          rt, wr;
            logic [5:0]    ad;
            logic [31:0]   wd;
            rq = NS'($urandom & $urandom & $urandom);
            ce = (($urandom % 16) == 0) ? 7'(1 << ($urandom % 7)) : 7'h0;
            rt = (($urandom % 4) == 0);
            wr = (($urandom % 16) == 0);
            wd = $urandom;
            ad = 6'($urandom % 64);
            if (wr) begin
                case ($urandom % 4)
                    0: begin ad = AMSK; wd = wd | 32'hC000; end
                    1: ad = AEN;
                    2: begin ad = AMAP + 6'($urandom % NS); wd = 32'($urandom % 16); end
                    default: ad = 6'($urandom % 16);
                endcase
            end
            step(rq, ce, rt, wr, ad, wd);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule